// File: doc/BRIEF.md
# DQS Delay Eye Scan Controller

The block measures how wide the data eye of each byte lane is by moving a strobe delay setting and asking an external test engine to run a memory test at each setting. The delay is counted in 1/256 of a clock cycle, so a value of 256 would be one whole cycle. The nominal position is 64, a quarter cycle. For each step the block raises a run request and holds the delay steady. The engine answers with a one-cycle done pulse and a pass bit for each of the four lanes.

Two scan modes exist. The read scan climbs from 64 in steps of 4 until no lane still passes. It then descends from 60 until no lane still passes. The write scan visits every setting from 16 to 112 in steps of 4. In both modes a lane's eye is the unbroken run of passing settings that contains 64. The block reports the width and the centre of that run for each lane. At the end of the scan every lane's delay returns to the setting captured at start. The exception is a write scan with centre mode on: there each lane that has an eye keeps its measured centre.

Top module: `dqs_eye_scan`

## Requirements
- R1: After reset, busy, done and test_req are 0 and every lane's dly_out is 64.
- R2: Each step holds test_req high until test_done is seen. Every lane's dly_out keeps the same value throughout that wait. test_req then drops for exactly one cycle before the next step.
- R3: A read scan (scan_write=0) issues 64, 68, 72 and so on. It stops after the first setting at which no lane that passed at 64 is still passing. It also stops after 252 if some lane still passes there.
- R4: The downward pass of a read scan issues 60, 56 and so on. It stops after the first setting at which every lane has failed, or after 0. The pass is skipped entirely when no lane passed at 64.
- R5: A write scan (scan_write=1) issues every setting 16, 20, ..., 112 regardless of the results.
- R6: A lane's eye is the longest run of consecutive issued settings that all pass and that includes 64. Its 8-bit width field, at bits [8l+7:8l], is high minus low. Its centre field is floor((low+high)/2). A lane that fails at 64 reports width 0 and centre 64.
- R7: When the scan ends, each lane's dly_out takes the orig_dly value captured at start. This covers a read scan and a write scan without centre mode.
- R8: When a write scan was started with centre_en=1, each lane with an eye takes its reported centre as dly_out. A lane without an eye takes its captured orig_dly.
- R9: done is a one-cycle pulse in the cycle after busy falls. A start pulse while busy is ignored, together with the scan_write and centre_en values it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| scan_write | input | 1 | 0 = read scan, 1 = write scan |
| centre_en | input | 1 | Leave measured centre applied after a write scan |
| orig_dly | input | 32 | Per-lane setting to restore, lane l at [8l+7:8l] |
| test_done | input | 1 | Test engine finished the current step |
| test_pass | input | 4 | Per-lane pass result, valid with test_done |
| test_req | output | 1 | Run a memory test at the current delay |
| dly_out | output | 32 | Per-lane delay setting, lane l at [8l+7:8l] |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at scan end |
| eye_width | output | 32 | Per-lane eye width |
| eye_centre | output | 32 | Per-lane eye centre |

## Verification
The hardest situations to reach are the edges of the read scan. One is a lane whose eye reaches the top of the delay range, so the upward pass ends at 252 with lanes still alive. Another is a lane whose eye reaches 0. A third is the case where no lane passes at 64 and the downward pass must not run at all. The bench's model of the test engine passes a lane when the delay falls inside a per-lane window, minus an optional single hole. Dedicated window sets drive each of these cases. A swept family of windows covers the ordinary shapes in both modes. The bench derives each issued delay sequence, eye and final setting from the windows by walking the 4-unit grid.

// File: rtl/dqs_scan_pkg.sv
package dqs_scan_pkg;
  localparam int DLY_W = 8;

  typedef enum logic [1:0] {PH_RD_UP, PH_RD_DN, PH_WR} scan_phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EVAL, ST_DONE} scan_state_e;

  // eye width: span between the two edges, zero when no eye exists
  function automatic logic [DLY_W-1:0] span_of(input logic v,
                                               input logic [DLY_W-1:0] lo,
                                               input logic [DLY_W-1:0] hi);
    return v ? DLY_W'(hi - lo) : '0;
  endfunction

  // eye centre: floor of the edge mean, nominal position when no eye exists
  function automatic logic [DLY_W-1:0] mid_of(input logic v,
                                              input logic [DLY_W-1:0] lo,
                                              input logic [DLY_W-1:0] hi,
                                              input logic [DLY_W-1:0] dflt);
    logic [DLY_W:0] sum;
    sum = {1'b0, lo} + {1'b0, hi};
    return v ? sum[DLY_W:1] : dflt;
  endfunction
endpackage

// File: rtl/dqs_lane_track.sv
module dqs_lane_track
  import dqs_scan_pkg::*;
#(
  parameter int DEF = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rearm,
  input  logic             upd,
  input  scan_phase_e      phase,
  input  logic [DLY_W-1:0] d,
  input  logic             p,
  output logic             valid,
  output logic             alive,
  output logic [DLY_W-1:0] lo,
  output logic [DLY_W-1:0] hi
);
  localparam logic [DLY_W-1:0] DEF_B = DLY_W'(DEF);

  logic run;  // write scan: unbroken passing run below the nominal point

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      valid <= 1'b0;
      alive <= 1'b0;
      run   <= 1'b0;
      lo    <= DEF_B;
      hi    <= DEF_B;
    end else if (rearm) begin
      alive <= valid;
    end else if (upd) begin
      case (phase)
        PH_RD_UP: begin
          if (d == DEF_B) begin
            valid <= p;
            alive <= p;
          end else if (alive) begin
            if (p) hi <= d;
            else   alive <= 1'b0;
          end
        end
        PH_RD_DN: begin
          if (alive) begin
            if (p) lo <= d;
            else   alive <= 1'b0;
          end
        end
        default: begin
          if (d < DEF_B) begin
            if (p) begin
              if (!run) lo <= d;
              run <= 1'b1;
            end else begin
              run <= 1'b0;
            end
          end else if (d == DEF_B) begin
            valid <= p;
            alive <= p;
            if (p && !run) lo <= d;
          end else if (alive) begin
            if (p) hi <= d;
            else   alive <= 1'b0;
          end
        end
      endcase
    end
  end

  assert_eye_spans_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (lo <= DEF_B && hi >= DEF_B));
endmodule

// File: rtl/dqs_scan_seq.sv
module dqs_scan_seq
  import dqs_scan_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEF    = 64,
  parameter int STEP   = 4,
  parameter int WR_MIN = 16,
  parameter int WR_MAX = 112
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scan_write,
  input  logic             centre_en,
  input  logic             test_done,
  input  logic [LANES-1:0] lane_alive,
  input  logic [LANES-1:0] lane_valid,
  output logic [DLY_W-1:0] scan_d,
  output scan_phase_e      phase,
  output logic             busy,
  output logic             done,
  output logic             test_req,
  output logic             upd,
  output logic             rearm,
  output logic             launch,
  output logic             finish,
  output logic             mode_q,
  output logic             centre_q
);
  localparam int               UP_LAST  = (1 << DLY_W) - 1 - STEP;
  localparam int               WR_LAST  = WR_MAX - STEP;
  localparam logic [DLY_W-1:0] STEP_B   = DLY_W'(STEP);
  localparam logic [DLY_W-1:0] DEF_B    = DLY_W'(DEF);
  localparam logic [DLY_W-1:0] DN_START = DLY_W'(DEF - STEP);
  localparam logic [DLY_W-1:0] WMIN_B   = DLY_W'(WR_MIN);

  scan_state_e state;
  logic go_down, end_scan;

  assign busy     = (state == ST_WAIT) || (state == ST_EVAL);
  assign done     = (state == ST_DONE);
  assign test_req = (state == ST_WAIT);
  assign upd      = test_req && test_done;
  assign launch   = (state == ST_IDLE) && start;
  assign rearm    = go_down;
  assign finish   = end_scan;

  always_comb begin
    go_down  = 1'b0;
    end_scan = 1'b0;
    if (state == ST_EVAL) begin
      case (phase)
        PH_RD_UP: begin
          if (lane_alive == '0 || int'(scan_d) > UP_LAST) begin
            if (|lane_valid) go_down  = 1'b1;
            else             end_scan = 1'b1;
          end
        end
        PH_RD_DN: begin
          if (lane_alive == '0 || int'(scan_d) < STEP) end_scan = 1'b1;
        end
        default: begin
          if (int'(scan_d) > WR_LAST) end_scan = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_RD_UP;
      scan_d   <= DEF_B;
      mode_q   <= 1'b0;
      centre_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= scan_write;
            centre_q <= centre_en;
            phase    <= scan_write ? PH_WR : PH_RD_UP;
            scan_d   <= scan_write ? WMIN_B : DEF_B;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: if (test_done) state <= ST_EVAL;
        ST_EVAL: begin
          if (end_scan) begin
            state <= ST_DONE;
          end else if (go_down) begin
            phase  <= PH_RD_DN;
            scan_d <= DN_START;
            state  <= ST_WAIT;
          end else begin
            scan_d <= (phase == PH_RD_DN) ? scan_d - STEP_B : scan_d + STEP_B;
            state  <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_done) |=> test_req);
  assert_dly_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_done) |=> $stable(scan_d));
  assert_write_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_WR) |-> (int'(scan_d) >= WR_MIN && int'(scan_d) <= WR_MAX));
  assert_down_below_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_RD_DN) |-> (scan_d < DEF_B));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dqs_eye_scan.sv
module dqs_eye_scan
  import dqs_scan_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEF    = 64,
  parameter int STEP   = 4,
  parameter int WR_MIN = 16,
  parameter int WR_MAX = 112
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   scan_write,
  input  logic                   centre_en,
  input  logic [LANES*DLY_W-1:0] orig_dly,
  input  logic                   test_done,
  input  logic [LANES-1:0]       test_pass,
  output logic                   test_req,
  output logic [LANES*DLY_W-1:0] dly_out,
  output logic                   busy,
  output logic                   done,
  output logic [LANES*DLY_W-1:0] eye_width,
  output logic [LANES*DLY_W-1:0] eye_centre
);
  localparam logic [DLY_W-1:0] DEF_B = DLY_W'(DEF);

  logic [DLY_W-1:0] scan_d;
  scan_phase_e      phase;
  logic             upd, rearm, launch, finish, mode_q, centre_q;
  logic [LANES-1:0] lane_alive, lane_valid;
  logic [LANES*DLY_W-1:0] orig_q, applied;

  dqs_scan_seq #(
    .LANES(LANES), .DEF(DEF), .STEP(STEP), .WR_MIN(WR_MIN), .WR_MAX(WR_MAX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_write(scan_write),
    .centre_en(centre_en), .test_done(test_done), .lane_alive(lane_alive),
    .lane_valid(lane_valid), .scan_d(scan_d), .phase(phase), .busy(busy),
    .done(done), .test_req(test_req), .upd(upd), .rearm(rearm),
    .launch(launch), .finish(finish), .mode_q(mode_q), .centre_q(centre_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DLY_W-1:0] lo, hi, span, mid;

    dqs_lane_track #(.DEF(DEF)) u_track (
      .clk(clk), .rst_n(rst_n), .clr(launch), .rearm(rearm), .upd(upd),
      .phase(phase), .d(scan_d), .p(test_pass[l]), .valid(lane_valid[l]),
      .alive(lane_alive[l]), .lo(lo), .hi(hi)
    );

    assign span = span_of(lane_valid[l], lo, hi);
    assign mid  = mid_of(lane_valid[l], lo, hi, DEF_B);
    assign eye_width[l*DLY_W +: DLY_W]  = span;
    assign eye_centre[l*DLY_W +: DLY_W] = mid;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        orig_q[l*DLY_W +: DLY_W]  <= DEF_B;
        applied[l*DLY_W +: DLY_W] <= DEF_B;
      end else begin
        if (launch) orig_q[l*DLY_W +: DLY_W] <= orig_dly[l*DLY_W +: DLY_W];
        if (finish)
          applied[l*DLY_W +: DLY_W] <= (mode_q && centre_q && lane_valid[l])
                                       ? mid : orig_q[l*DLY_W +: DLY_W];
      end
    end

    assign dly_out[l*DLY_W +: DLY_W] = busy ? scan_d : applied[l*DLY_W +: DLY_W];

    assert_centre_applied_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q && centre_q && lane_valid[l]) |-> (dly_out[l*DLY_W +: DLY_W] == mid));
  end

  assert_restore_original_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(mode_q && centre_q)) |-> (dly_out == orig_q));
endmodule

// File: tb/dqs_eye_scan_bench.sv
module dqs_eye_scan_bench;
  localparam int LANES = 4;
  localparam int DEF = 64;
  localparam int STEP = 4;
  localparam int WMIN = 16;
  localparam int WMAX = 112;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, scan_write, centre_en, test_done, test_req, busy, done;
  logic [LANES-1:0] test_pass;
  logic [LANES*8-1:0] orig_dly, dly_out, eye_width, eye_centre;

  dqs_eye_scan u_dqs_eye_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_write(scan_write),
    .centre_en(centre_en), .orig_dly(orig_dly), .test_done(test_done),
    .test_pass(test_pass), .test_req(test_req), .dly_out(dly_out),
    .busy(busy), .done(done), .eye_width(eye_width), .eye_centre(eye_centre)
  );

  int checks = 0;
  int errors = 0;
  int wlo[LANES], whi[LANES], hole[LANES];
  int seq[256];
  int nseq;
  int lane_split;
  int gap_err;

  function automatic bit lane_ok(int l, int d);
    return d >= wlo[l] && d <= whi[l] && d != hole[l];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // test engine model: answers two cycles after each request
  initial begin
    int lat;
    bit pend;
    bit prev_req;
    pend = 0; lat = 0; prev_req = 0;
    test_done = 1'b0; test_pass = '0;
    forever begin
      @(negedge clk);
      test_done = 1'b0;
      if (pend) begin
        if (!test_req) gap_err++;
        if (dly_out[7:0] != 8'(seq[nseq-1])) lane_split++;
        lat--;
        if (lat == 0) begin
          for (int l = 0; l < LANES; l++) test_pass[l] = lane_ok(l, int'(dly_out[7:0]));
          test_done = 1'b1;
          pend = 0;
        end
      end else if (test_req) begin
        if (prev_req) gap_err++;
        for (int l = 1; l < LANES; l++)
          if (dly_out[l*8 +: 8] != dly_out[7:0]) lane_split++;
        if (nseq < 256) seq[nseq] = int'(dly_out[7:0]);
        nseq++;
        lat = 2;
        pend = 1;
      end
      prev_req = test_req;
    end
  end

  task automatic run_scan(bit wr, bit ctr, string tag);
    int lo_e[LANES], hi_e[LANES], exp_seq[256];
    bit v[LANES];
    int n_e, top, bot, cyc, orig[LANES], c;
    bit anyv;
    for (int l = 0; l < LANES; l++) begin
      orig[l] = (37 * l + 5 + (wr ? 100 : 0) + (ctr ? 50 : 0)) % 256;
      orig_dly[l*8 +: 8] = 8'(orig[l]);
    end
    nseq = 0; lane_split = 0; gap_err = 0;
    scan_write = wr; centre_en = ctr;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9", {tag, " busy after start"}, int'(busy), 1);
    // a start while busy, with the other mode, must change nothing
    scan_write = !wr; centre_en = !ctr; start = 1'b1;
    @(negedge clk) start = 1'b0; scan_write = wr; centre_en = ctr;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk("R9", {tag, " scan completes"}, int'(done), 1);
    // expected eyes by walking the grid
    anyv = 0;
    for (int l = 0; l < LANES; l++) begin
      v[l] = lane_ok(l, DEF);
      lo_e[l] = DEF; hi_e[l] = DEF;
      bot = wr ? WMIN : 0; top = wr ? WMAX : 252;
      while (lo_e[l] - STEP >= bot && lane_ok(l, lo_e[l] - STEP)) lo_e[l] -= STEP;
      while (hi_e[l] + STEP <= top && lane_ok(l, hi_e[l] + STEP)) hi_e[l] += STEP;
      if (v[l]) anyv = 1;
    end
    n_e = 0;
    if (wr) begin
      for (int d = WMIN; d <= WMAX; d += STEP) begin exp_seq[n_e] = d; n_e++; end
    end else begin
      top = DEF; bot = 252;
      for (int l = 0; l < LANES; l++)
        if (v[l]) begin
          if (hi_e[l] + STEP > top) top = hi_e[l] + STEP;
          if (lo_e[l] - STEP < bot) bot = lo_e[l] - STEP;
        end
      if (top > 252) top = 252;
      if (bot < 0) bot = 0;
      for (int d = DEF; d <= top; d += STEP) begin exp_seq[n_e] = d; n_e++; end
      if (anyv)
        for (int d = DEF - STEP; d >= bot; d -= STEP) begin exp_seq[n_e] = d; n_e++; end
    end
    chk(wr ? "R5" : "R3", {tag, " step count"}, nseq, n_e);
    c = 0;
    for (int i = 0; i < n_e && i < nseq; i++) if (seq[i] != exp_seq[i]) c++;
    chk(wr ? "R5" : "R4", {tag, " delay sequence mismatches"}, c, 0);
    chk("R2", {tag, " lanes split or delay moved while waiting"}, lane_split, 0);
    chk("R2", {tag, " request gap violations"}, gap_err, 0);
    for (int l = 0; l < LANES; l++) begin
      chk("R6", $sformatf("%s lane%0d width", tag, l), int'(eye_width[l*8 +: 8]),
          v[l] ? hi_e[l] - lo_e[l] : 0);
      chk("R6", $sformatf("%s lane%0d centre", tag, l), int'(eye_centre[l*8 +: 8]),
          v[l] ? (lo_e[l] + hi_e[l]) / 2 : DEF);
      if (wr && ctr && v[l])
        chk("R8", $sformatf("%s lane%0d centred delay", tag, l), int'(dly_out[l*8 +: 8]),
            (lo_e[l] + hi_e[l]) / 2);
      else
        chk("R7", $sformatf("%s lane%0d restored delay", tag, l), int'(dly_out[l*8 +: 8]),
            orig[l]);
    end
    @(negedge clk);
    chk("R9", {tag, " done lasts one cycle"}, int'(done), 0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; scan_write = 1'b0; centre_en = 1'b0; orig_dly = '0;
    for (int l = 0; l < LANES; l++) begin wlo[l] = 0; whi[l] = 255; hole[l] = -1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "test_req after reset", int'(test_req), 0);
    for (int l = 0; l < LANES; l++)
      chk("R1", $sformatf("lane%0d delay after reset", l), int'(dly_out[l*8 +: 8]), DEF);

    // edge windows: top of range, bottom of range, no eye, hole, one-point eye
    wlo[0] = 0;  whi[0] = 255; hole[0] = -1;
    wlo[1] = 70; whi[1] = 200; hole[1] = -1;
    wlo[2] = 20; whi[2] = 100; hole[2] = 40;
    wlo[3] = 64; whi[3] = 64;  hole[3] = -1;
    run_scan(0, 0, "edge-read");
    run_scan(1, 1, "edge-write-centre");
    run_scan(1, 0, "edge-write");

    // no lane passes at the nominal point: downward pass skipped
    for (int l = 0; l < LANES; l++) begin wlo[l] = 100; whi[l] = 120; hole[l] = -1; end
    run_scan(0, 0, "noeye-read");
    run_scan(1, 1, "noeye-write");

    // swept window family
    for (int k = 0; k < 7; k++) begin
      for (int l = 0; l < LANES; l++) begin
        wlo[l] = DEF - ((k * 7 + l * 13) % 50);
        whi[l] = DEF + ((k * 11 + l * 5) % 60);
        hole[l] = ((k + l) % 3 == 0) ? DEF - 4 * ((k + l) % 5) - 8 : -1;
        if (k > 4 && (k + l) % 4 == 0) wlo[l] = DEF + 6;
      end
      run_scan(0, k[0], $sformatf("sweep%0d-read", k));
      run_scan(1, k[0], $sformatf("sweep%0d-write", k));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule